// File: doc/BRIEF.md
# Nibble Microsequencer with Flag Branching

A small microcoded execution engine with a 4-bit datapath. Each clock cycle it executes the microword at its current microaddress. The microword is supplied by an external microcode ROM: the microaddress goes out on `uaddr_o` and the ROM answers on `uword_i` in the same cycle. One microword can run an ALU operation into a destination register, read or write a behavioural RAM, and choose the next microaddress. That choice is either fixed or is a two-way branch on the zero or carry flag.

Three address nibbles `t`, `u` and `v` form a 12-bit memory address, with `t` most significant. The installed memory has only 2K words, so the upper half of the address space aliases onto the lower half. Two data registers `ka` and `kb` are loaded by the ALU only. The `ca` register is the data path to and from the RAM. Multi-nibble counters are built in microcode: a register is incremented, and the engine branches on its rollover to increment the next higher register.

Top module: `nib_useq`

## Requirements
- R1: While `rst_ni` is low, `uaddr_o` is 0x000, all six registers read 0, and both flags read 0.
- R2: The microword layout, MSB to LSB, is op[27], a_sel[26:24], b_sel[23:21], cin[20], dst[19:17], flag_we[16], mem[15:14], cond[13:12], next[11:0]. With cond = 0 the following microaddress is `next`.
- R3: op = 0 computes A + B + cin. op = 1 computes A xor 0xF. The 4-bit result goes to the register chosen by dst, and every other register holds. The register codes, used by a_sel, b_sel and dst, are 0 none (reads 0, write discarded), 1 T, 2 U, 3 V, 4 CA, 5 KA, 6 KB.
- R4: The zero flag is 1 when the 4-bit result is 0. The carry flag is the bit-4 carry of the add, and it is 0 for xor. Both flags load only on microwords with flag_we = 1 and hold otherwise.
- R5: cond = 1 tests zero and cond = 2 tests carry. The following microaddress is {next[11:1], flag}, so a flag of 1 selects the odd target. The flag tested is the one the same microword produces when flag_we = 1, and otherwise the held flag.
- R6: mem = 1 loads CA from RAM at {T,U,V}, and this takes priority over an ALU write to CA. mem = 2 stores the CA value from before the edge at {T,U,V}. T is the most significant nibble.
- R7: Only the low 11 address bits select a RAM word, so addresses that differ only in bit 11 access the same word.
- R8: A V→U→T ripple counter written in microcode counts all 4096 states and ends back at zero. It does so with branches on zero and with branches on carry alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| uword_i | input | 28 | Microword read from ROM at `uaddr_o` |
| uaddr_o | output | 12 | Current microaddress |
| t_o | output | 4 | Address nibble T (most significant) |
| u_o | output | 4 | Address nibble U |
| v_o | output | 4 | Address nibble V (least significant) |
| ca_o | output | 4 | RAM data register |
| ka_o | output | 4 | Data register KA |
| kb_o | output | 4 | Data register KB |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |

## Verification
The assertions assume the ROM returns a fully defined microword for every microaddress the engine can reach, with no reserved codes in cond or mem. The bench ROM is fully decoded and sends any unlisted address to a self-loop that the watchdog catches.

The microcode sweeps the full 4096-state counter, first with zero branches and then with carry branches. It writes an address-dependent value, reads it back, and in the upper half first reads the aliased word. A prologue uses an xor and an add to make the two flags differ before the ripple starts, so a swapped flag select would take the wrong branch.

// File: rtl/nib_pkg.sv
package nib_pkg;
  localparam int NW      = 4;
  localparam int UADDR_W = 12;

  typedef enum logic [2:0] {
    R_NONE, R_T, R_U, R_V, R_CA, R_KA, R_KB, R_RSV
  } rsel_e;

  typedef enum logic {OP_ADD, OP_XORF} alu_op_e;

  typedef enum logic [1:0] {MEM_NONE, MEM_RD, MEM_WR, MEM_RSV} mem_op_e;

  typedef enum logic [1:0] {BR_NONE, BR_ZERO, BR_CARRY, BR_RSV} cond_e;

  typedef struct packed {
    alu_op_e              op;
    rsel_e                a_sel;
    rsel_e                b_sel;
    logic                 cin;
    rsel_e                dst;
    logic                 flag_we;
    mem_op_e              mem;
    cond_e                cond;
    logic [UADDR_W-1:0]   next;
  } uword_t;

  localparam int UW_W = $bits(uword_t);
endpackage

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int W = NW
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         zero_o,
  output logic         carry_o
);
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    if (op_i == OP_XORF) begin
      res_o   = a_i ^ {W{1'b1}};
      carry_o = 1'b0;
    end else begin
      res_o   = sum[W-1:0];
      carry_o = sum[W];
    end
    zero_o = (res_o == '0);
  end
endmodule

// File: rtl/nib_regs.sv
module nib_regs
  import nib_pkg::*;
#(
  parameter int W = NW
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  rsel_e        a_sel_i,
  input  rsel_e        b_sel_i,
  input  rsel_e        dst_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_en_i,
  input  logic [W-1:0] rd_data_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] t_o,
  output logic [W-1:0] u_o,
  output logic [W-1:0] v_o,
  output logic [W-1:0] ca_o,
  output logic [W-1:0] ka_o,
  output logic [W-1:0] kb_o
);
  localparam int NREG = 8;

  logic [W-1:0] rf_q [NREG];
  logic [NREG-1:0] we;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      we[i] = (i != int'(R_NONE)) && (i != int'(R_RSV)) && (dst_i == rsel_e'(i));
    end
    // RAM load owns CA
    we[R_CA] = we[R_CA] | rd_en_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (we[i]) begin
          if (i == int'(R_CA) && rd_en_i) rf_q[i] <= rd_data_i;
          else                            rf_q[i] <= wdata_i;
        end
      end
    end
  end

  assign a_o  = rf_q[a_sel_i];
  assign b_o  = rf_q[b_sel_i];
  assign t_o  = rf_q[R_T];
  assign u_o  = rf_q[R_U];
  assign v_o  = rf_q[R_V];
  assign ca_o = rf_q[R_CA];
  assign ka_o = rf_q[R_KA];
  assign kb_o = rf_q[R_KB];

  // R6
  ca_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> (ca_o == $past(rd_data_i)));

  // R3
  ka_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i != R_KA) |=> $stable(ka_o));

  // R3
  t_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dst_i != R_T) |=> $stable(t_o));
endmodule

// File: rtl/nib_seq.sv
module nib_seq
  import nib_pkg::*;
#(
  parameter int AW = UADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cond_e         cond_i,
  input  logic [AW-1:0] next_i,
  input  logic          flag_we_i,
  input  logic          zero_i,
  input  logic          carry_i,
  output logic [AW-1:0] uaddr_o,
  output logic          zero_o,
  output logic          carry_o
);
  logic [AW-1:0] uaddr_q;
  logic          zero_q, carry_q;
  logic          zero_n, carry_n, tst;

  always_comb begin
    zero_n  = flag_we_i ? zero_i  : zero_q;
    carry_n = flag_we_i ? carry_i : carry_q;
    case (cond_i)
      BR_ZERO:  tst = zero_n;
      BR_CARRY: tst = carry_n;
      default:  tst = next_i[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uaddr_q <= '0;
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      uaddr_q <= {next_i[AW-1:1], tst};
      zero_q  <= zero_n;
      carry_q <= carry_n;
    end
  end

  assign uaddr_o = uaddr_q;
  assign zero_o  = zero_q;
  assign carry_o = carry_q;

  // R2
  seq_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == BR_NONE) |=> (uaddr_q == $past(next_i)));

  // R4
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> ($stable(zero_q) && $stable(carry_q)));

  // R5
  zero_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == BR_ZERO && flag_we_i) |=> (uaddr_q[0] == zero_q));

  // R5
  carry_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == BR_CARRY && flag_we_i) |=> (uaddr_q[0] == carry_q));
endmodule

// File: rtl/nib_ram.sv
module nib_ram #(
  parameter int AW = 11,
  parameter int W  = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/nib_useq.sv
module nib_useq
  import nib_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [UW_W-1:0]     uword_i,
  output logic [UADDR_W-1:0]  uaddr_o,
  output logic [NW-1:0]       t_o,
  output logic [NW-1:0]       u_o,
  output logic [NW-1:0]       v_o,
  output logic [NW-1:0]       ca_o,
  output logic [NW-1:0]       ka_o,
  output logic [NW-1:0]       kb_o,
  output logic                zero_o,
  output logic                carry_o
);
  localparam int FULL_AW = 3 * NW;

  uword_t              uw;
  logic [NW-1:0]       a_val, b_val, res;
  logic                alu_zero, alu_carry;
  logic [NW-1:0]       t, u, v, ca;
  logic [FULL_AW-1:0]  addr_full;
  logic [MEM_AW-1:0]   mem_addr;
  logic [NW-1:0]       ram_rdata;

  assign uw        = uword_t'(uword_i);
  assign addr_full = {t, u, v};
  // upper half mirrors onto installed words
  assign mem_addr  = MEM_AW'(addr_full);

  nib_alu #(.W(NW)) u_alu (
    .op_i    (uw.op),
    .a_i     (a_val),
    .b_i     (b_val),
    .cin_i   (uw.cin),
    .res_o   (res),
    .zero_o  (alu_zero),
    .carry_o (alu_carry)
  );

  nib_regs #(.W(NW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_sel_i   (uw.a_sel),
    .b_sel_i   (uw.b_sel),
    .dst_i     (uw.dst),
    .wdata_i   (res),
    .rd_en_i   (uw.mem == MEM_RD),
    .rd_data_i (ram_rdata),
    .a_o       (a_val),
    .b_o       (b_val),
    .t_o       (t),
    .u_o       (u),
    .v_o       (v),
    .ca_o      (ca),
    .ka_o      (ka_o),
    .kb_o      (kb_o)
  );

  nib_ram #(.AW(MEM_AW), .W(NW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (uw.mem == MEM_WR),
    .addr_i  (mem_addr),
    .wdata_i (ca),
    .rdata_o (ram_rdata)
  );

  nib_seq #(.AW(UADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (uw.cond),
    .next_i    (uw.next),
    .flag_we_i (uw.flag_we),
    .zero_i    (alu_zero),
    .carry_i   (alu_carry),
    .uaddr_o   (uaddr_o),
    .zero_o    (zero_o),
    .carry_o   (carry_o)
  );

  assign t_o  = t;
  assign u_o  = u;
  assign v_o  = v;
  assign ca_o = ca;
endmodule

// File: tb/nib_useq_test.sv
`timescale 1ns/1ps
module nib_useq_test;
  localparam logic [2:0] N = 3'd0, T = 3'd1, U = 3'd2, V = 3'd3,
                         CA = 3'd4, KA = 3'd5, KB = 3'd6;
  localparam int RUN_LIMIT = 70000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        variant = 1'b0;
  logic [27:0] uword;
  logic [11:0] uaddr;
  logic [3:0]  t_o, u_o, v_o, ca_o, ka_o, kb_o;
  logic        zero_o, carry_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  function automatic logic [27:0] mw(logic op, logic [2:0] a, logic [2:0] b,
                                     logic cin, logic [2:0] dst, logic fwe,
                                     logic [1:0] mem, logic [1:0] cond,
                                     logic [11:0] nxt);
    return {op, a, b, cin, dst, fwe, mem, cond, nxt};
  endfunction

  function automatic logic [27:0] rom(logic [11:0] a, logic cv);
    logic [1:0] c;
    c = cv ? 2'd2 : 2'd1;
    case (a)
      12'h000: return mw(0, N, N, 0, T, 0, 0, 0, 12'h001);
      12'h001: return mw(0, N, N, 0, U, 0, 0, 0, 12'h002);
      12'h002: return mw(0, N, N, 0, V, 0, 0, 0, 12'h003);
      12'h003: return mw(1, N, N, 0, CA, 1, 0, 1, 12'h020);   // CA=F, z=0
      12'h020: return mw(0, CA, CA, 0, KA, 1, 0, c, 12'h022); // E, z=0 c=1
      12'h022: return mw(0, N, N, 0, N, 0, 0, 0, 12'h004);
      12'h023: return mw(0, N, N, 0, N, 0, 0, 0, 12'h004);
      12'h004: return mw(0, N, N, 0, N, 0, 1, 0, 12'h005);
      12'h005: return mw(0, CA, N, 1, KB, 0, 0, 0, 12'h006);
      12'h006: return mw(1, V, N, 0, CA, 0, 0, 0, 12'h007);
      12'h007: return mw(0, CA, U, 0, CA, 0, 0, 0, 12'h008);
      12'h008: return mw(0, CA, T, 0, CA, 0, 0, 0, 12'h009);
      12'h009: return mw(0, N, N, 0, N, 0, 2, 0, 12'h00A);
      12'h00A: return mw(0, N, N, 0, CA, 0, 0, 0, 12'h00B);
      12'h00B: return mw(0, N, N, 0, N, 0, 1, 0, 12'h010);
      12'h010: return mw(0, CA, N, 0, KA, 0, 0, 0, 12'h011);
      12'h011: return mw(0, V, N, 1, V, 1, 0, c, 12'h012);
      12'h012: return mw(0, N, N, 0, N, 0, 0, 0, 12'h004);
      12'h013: return mw(0, U, N, 1, U, 1, 0, c, 12'h014);
      12'h014: return mw(0, N, N, 0, N, 0, 0, 0, 12'h004);
      12'h015: return mw(0, T, N, 1, T, 1, 0, c, 12'h016);
      12'h016: return mw(0, N, N, 0, N, 0, 0, 1, 12'h018);   // held zero flag
      12'h018: return mw(0, N, N, 0, N, 0, 0, 0, 12'h004);
      default: return mw(0, N, N, 0, N, 0, 0, 0, a);         // trap / halt
    endcase
  endfunction

  function automatic logic [3:0] pat(logic [3:0] tt, logic [3:0] uu, logic [3:0] vv);
    return (~vv) + uu + tt;
  endfunction

  assign uword = rom(uaddr, variant);

  nib_useq uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .uword_i (uword),
    .uaddr_o (uaddr),
    .t_o     (t_o),
    .u_o     (u_o),
    .v_o     (v_o),
    .ca_o    (ca_o),
    .ka_o    (ka_o),
    .kb_o    (kb_o),
    .zero_o  (zero_o),
    .carry_o (carry_o)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(logic cv);
    logic [3:0] mt, mu, mv;
    int idx;
    int cyc;
    logic [3:0] old;
    variant = cv;
    rst_ni  = 1'b0;
    repeat (2) @(negedge clk);
    chk(uaddr == 12'h000, "R1 uaddr", uaddr, 0);
    chk({t_o, u_o, v_o, ca_o, ka_o, kb_o} == '0, "R1 regs",
        {t_o, u_o, v_o, ca_o, ka_o, kb_o}, 0);
    chk({zero_o, carry_o} == 2'b00, "R1 flags", {zero_o, carry_o}, 0);
    rst_ni = 1'b1;
    mt = 0; mu = 0; mv = 0; idx = 0; cyc = 0;
    while (uaddr != 12'h017 && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
      case (uaddr)
        12'h022, 12'h023: begin
          // R5: carry=1/zero=0 after E from F+F
          chk(uaddr == (cv ? 12'h023 : 12'h022), "R5 prologue branch", uaddr,
              cv ? 12'h023 : 12'h022);
          chk(ka_o == 4'hE, "R3 add F+F", ka_o, 4'hE);
          chk({zero_o, carry_o} == 2'b01, "R4 flags after add", {zero_o, carry_o}, 1);
        end
        12'h011: begin
          chk({t_o, u_o, v_o} == {mt, mu, mv}, "R8 counter", {t_o, u_o, v_o},
              {mt, mu, mv});
          chk(ka_o == pat(mt, mu, mv), "R6 readback", ka_o, pat(mt, mu, mv));
          if (idx >= 2048) begin
            old = pat(mt - 4'd8, mu, mv) + 4'd1;
            chk(kb_o == old, "R7 alias read", kb_o, old);
          end
          // R4: CA=0 and other ops with flag_we=0 must not disturb flags
          chk({zero_o, carry_o} == ((idx == 0) ? 2'b01 : 2'b00), "R4 hold",
              {zero_o, carry_o}, (idx == 0) ? 1 : 0);
          idx++;
          mv = mv + 4'd1;
          if (mv == 0) begin
            mu = mu + 4'd1;
            if (mu == 0) mt = mt + 4'd1;
          end
        end
        12'h012: begin
          if (v_o == 0 || {zero_o, carry_o} != 2'b00)
            chk(1'b0, "R5 even target", {v_o, zero_o, carry_o}, 0);
        end
        12'h013: begin
          chk(v_o == 0 && {zero_o, carry_o} == 2'b11, "R5 odd target",
              {v_o, zero_o, carry_o}, 3);
        end
        12'h019, 12'h021: chk(1'b0, "R5 trap reached", uaddr, 0);
        default: ;
      endcase
    end
    chk(cyc < RUN_LIMIT, "R8 watchdog", cyc, RUN_LIMIT);
    chk(idx == 4096, "R8 count length", idx, 4096);
    chk({t_o, u_o, v_o} == 12'h000, "R8 wrap", {t_o, u_o, v_o}, 0);
    chk({zero_o, carry_o} == 2'b11, "R4 flags at halt", {zero_o, carry_o}, 3);
    repeat (3) @(negedge clk);
    chk(uaddr == 12'h017, "R2 halt self-loop", uaddr, 12'h017);
  endtask

  initial begin
    run(1'b0);
    run(1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule